// File: doc/BRIEF.md
# Indirect Object Memory Access Port

This block is a register window on a 16-bit host bus. Through it the host reaches several internal 32-bit word memories, called objects. The host first programs a 32-bit control word. The control word picks an object and a word address, and it sets one option to advance the address after reads and another to advance it after writes. Data then moves through two 16-bit data registers. One carries bits 15:0 of the addressed word and the other carries bits 31:16.

There are four implemented objects: a microcode store, a 4096-byte shared memory, a file of 64 registers that are 16 bits wide, and a transmitter-address match table. The other object codes have no storage behind them. Every address offset counts 32-bit words, so one increment step moves to the next word. A byte address is converted as follows: shift it right by 2 to get the word address, then use the low data register if the byte address is 32-bit aligned and the high data register otherwise.

Top module: `oma_port`

## Requirements
- R1: After a synchronous active-low reset, the committed control value is zero (address 0, object 0, both increment options off) and `bus_rdata` is zero.
- R2: A write to offset 0x0160 only stages control bits 15:0. The new control value takes effect when bits 31:16 are written at offset 0x0162. In the committed value, bit 25 enables read increment, bit 24 enables write increment, bits 18:16 hold the object code and bits 15:0 hold the word address. Reads of 0x0160 and 0x0162 return the committed value, and all other bits read as zero.
- R3: Offset 0x0164 accesses bits 15:0 of the addressed word and offset 0x0166 accesses bits 31:16. Read data appears on `bus_rdata` in the clock cycle after the read strobe and holds until the next read.
- R4: A read of 0x0166 with read increment enabled adds one to the word address after the access. The address wraps from 0xFFFF to 0x0000.
- R5: A write of 0x0166 with write increment enabled stores the data at the current address and then adds one to the word address.
- R6: Accesses to 0x0164 never change the address. Accesses to 0x0166 do not change it when the matching increment option is off.
- R7: Object code 0 selects the microcode store (64 words), code 1 the shared memory (1024 words), code 2 the register file (64 entries) and code 4 the match table (16 words). A write to one object leaves every other object unchanged.
- R8: An address at or beyond the selected object's size wraps modulo that size.
- R9: For object codes 3, 5, 6 and 7, data reads return zero and data writes have no effect.
- R10: For object code 2, only 0x0164 carries data. 0x0166 reads as zero and writes to it are dropped, but the increment options still act on it.
- R11: A bus offset outside 0x0160 to 0x0166 reads as zero, and writing to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | 16 | Byte offset of the register addressed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
Two functions can fall in one cycle: an access to the high data register both moves data and steps the address. A write to the high data register stores at the old address while the address counter advances on the same edge. The bench provokes this with increment-enabled write runs that fill each object, followed by readback at the addresses the model predicts. A read of the high data register with increment enabled is judged the same way: the returned word must come from the pre-increment address, and the address read back from the control register must be one higher.

// File: rtl/oma_pkg.sv
// Shared types and constants for the indirect object memory access port.
// Assumes a 16-bit host bus with byte offsets and one access per cycle.
package oma_pkg;

    localparam logic [15:0] OFS_CTL_LO = 16'h0160;
    localparam logic [15:0] OFS_CTL_HI = 16'h0162;
    localparam logic [15:0] OFS_DAT_LO = 16'h0164;
    localparam logic [15:0] OFS_DAT_HI = 16'h0166;

    typedef struct packed {
        logic        rd_inc;
        logic        wr_inc;
        logic [2:0]  obj;
        logic [15:0] addr;
    } oma_ctl_t;

    // Expand the committed fields into the 32-bit host view of the control word.
    function automatic logic [31:0] ctl_to_word(oma_ctl_t c);
        return {6'b0, c.rd_inc, c.wr_inc, 5'b0, c.obj, c.addr};
    endfunction

endpackage

// File: rtl/oma_ctrl.sv
// Control word holder and word-address counter.
// Bits 15:0 are staged on lo_we and committed with bits 31:16 on hi_we.
// step advances the address by one. The top never raises step together with hi_we.
module oma_ctrl
    import oma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo_we,
    input  logic        hi_we,
    input  logic        step,
    input  logic [15:0] wdata,
    output oma_ctl_t    ctl
);

    logic [15:0] stage_q;
    logic        unused_wbits;

    assign unused_wbits = ^{wdata[15:10], wdata[7:3]};

    // Stage the low half, commit on the high half, otherwise count on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            ctl     <= '0;
        end else begin
            if (lo_we) begin
                stage_q <= wdata;
            end
            if (hi_we) begin
                ctl.rd_inc <= wdata[9];
                ctl.wr_inc <= wdata[8];
                ctl.obj    <= wdata[2:0];
                ctl.addr   <= stage_q;
            end else if (step) begin
                ctl.addr <= ctl.addr + 16'd1;
            end
        end
    end

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hi_we) |=> (ctl.addr == $past(ctl.addr) + 16'd1)); // R4
    AST_LO_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !hi_we && !step) |=> (ctl == $past(ctl))); // R2
    AST_HI_COMMIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> (ctl.rd_inc == $past(wdata[9]) && ctl.obj == $past(wdata[2:0]))); // R2

endmodule

// File: rtl/oma_word_mem.sv
// Word memory for one object, with separately writable 16-bit halves.
// With HAS_HI = 0 there is no upper storage: the upper half reads as zero
// and writes to it are dropped. Storage has no reset.
module oma_word_mem #(
    parameter int DEPTH  = 64,
    parameter bit HAS_HI = 1'b1,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [IW-1:0] idx,
    input  logic [15:0]   wdata,
    output logic [31:0]   rdata
);

    logic [15:0] lo_q [DEPTH];

    // Store the lower half of the addressed word.
    always_ff @(posedge clk) begin
        if (we_lo) begin
            lo_q[idx] <= wdata;
        end
    end

    assign rdata[15:0] = lo_q[idx];

    generate
        if (HAS_HI) begin : g_hi
            logic [15:0] hi_q [DEPTH];

            // Store the upper half of the addressed word.
            always_ff @(posedge clk) begin
                if (we_hi) begin
                    hi_q[idx] <= wdata;
                end
            end

            assign rdata[31:16] = hi_q[idx];

            AST_HI_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
                (we_hi ##1 $stable(idx)) |-> (rdata[31:16] == $past(wdata))); // R3
        end else begin : g_no_hi
            logic unused_hi;
            assign unused_hi     = we_hi;
            assign rdata[31:16]  = '0;
        end
    endgenerate

    AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo ##1 $stable(idx)) |-> (rdata[15:0] == $past(wdata))); // R3

endmodule

// File: rtl/oma_port.sv
// Top of the indirect object memory access port.
// Decodes the four host registers, routes data accesses to the object picked by
// the control word and registers the read data. Assumes one access per cycle and
// object sizes that are powers of two, so the modulo wrap is a truncation.
module oma_port
    import oma_pkg::*;
#(
    parameter int UC_WORDS = 64,
    parameter int SH_WORDS = 1024,
    parameter int RF_WORDS = 64,
    parameter int MT_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata
);

    localparam int NSLOT = 4;
    localparam int SLOT_DEPTH [NSLOT] = '{UC_WORDS, SH_WORDS, RF_WORDS, MT_WORDS};
    localparam int SLOT_CODE  [NSLOT] = '{0, 1, 2, 4};
    localparam bit SLOT_HI    [NSLOT] = '{1'b1, 1'b1, 1'b0, 1'b1};

    logic        wr, rd;
    logic        hit_clo, hit_chi, hit_dlo, hit_dhi;
    logic        step;
    oma_ctl_t    ctl;
    logic [NSLOT-1:0] slot_hit;
    logic [31:0] slot_rd [NSLOT];
    logic [31:0] obj_word;
    logic [31:0] ctl_word;
    logic        obj_known;

    assign wr      = bus_sel &  bus_we;
    assign rd      = bus_sel & ~bus_we;
    assign hit_clo = (bus_addr == OFS_CTL_LO);
    assign hit_chi = (bus_addr == OFS_CTL_HI);
    assign hit_dlo = (bus_addr == OFS_DAT_LO);
    assign hit_dhi = (bus_addr == OFS_DAT_HI);
    assign step    = hit_dhi & ((wr & ctl.wr_inc) | (rd & ctl.rd_inc));
    assign ctl_word = ctl_to_word(ctl);

    oma_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_we (wr & hit_clo),
        .hi_we (wr & hit_chi),
        .step  (step),
        .wdata (bus_wdata),
        .ctl   (ctl)
    );

    generate
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            localparam int IW = $clog2(SLOT_DEPTH[s]);

            assign slot_hit[s] = (ctl.obj == 3'(SLOT_CODE[s]));

            oma_word_mem #(
                .DEPTH  (SLOT_DEPTH[s]),
                .HAS_HI (SLOT_HI[s])
            ) u_mem (
                .clk   (clk),
                .rst_n (rst_n),
                .we_lo (wr & hit_dlo & slot_hit[s]),
                .we_hi (wr & hit_dhi & slot_hit[s]),
                .idx   (ctl.addr[IW-1:0]),
                .wdata (bus_wdata),
                .rdata (slot_rd[s])
            );
        end
    endgenerate

    assign obj_known = |slot_hit;

    // Pick the word of the selected object, or zero for an object with no storage.
    always_comb begin
        obj_word = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (slot_hit[s]) begin
                obj_word = slot_rd[s];
            end
        end
    end

    // Register the read data of the addressed host register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd) begin
            unique case (1'b1)
                hit_clo: bus_rdata <= ctl_word[15:0];
                hit_chi: bus_rdata <= ctl_word[31:16];
                hit_dlo: bus_rdata <= obj_word[15:0];
                hit_dhi: bus_rdata <= obj_word[31:16];
                default: bus_rdata <= '0;
            endcase
        end
    end

    AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (hit_dlo || hit_dhi) && !obj_known) |=> (bus_rdata == 16'h0)); // R9
    AST_REGFILE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_dhi && ctl.obj == 3'd2) |=> (bus_rdata == 16'h0)); // R10
    AST_LO_DATA_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && hit_dlo) |=> $stable(ctl.addr)); // R6
    AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !(hit_clo || hit_chi || hit_dlo || hit_dhi)) |=> (bus_rdata == 16'h0)); // R11
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata)); // R3

endmodule

// File: tb/oma_port_tb_top.sv
// Self-checking bench: a reference model of the objects and the control word,
// constrained random traffic from a fixed seed, and directed corner cases.
module oma_port_tb_top;

    localparam int UC = 64, SH = 1024, RF = 64, MT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // reference model
    logic [31:0] m_uc [UC];
    logic [31:0] m_sh [SH];
    logic [15:0] m_rf [RF];
    logic [31:0] m_mt [MT];
    logic        m_rdi, m_wri;
    logic [2:0]  m_obj;
    logic [15:0] m_addr, m_stage;

    always #2.5 clk = ~clk;

    oma_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] m_ctl();
        return {6'b0, m_rdi, m_wri, 5'b0, m_obj, m_addr};
    endfunction

    function automatic logic [31:0] m_word();
        case (m_obj)
            3'd0: return m_uc[m_addr % UC];
            3'd1: return m_sh[m_addr % SH];
            3'd2: return {16'h0, m_rf[m_addr % RF]};
            3'd4: return m_mt[m_addr % MT];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] m_read(logic [15:0] a);
        logic [31:0] c, w;
        c = m_ctl();
        w = m_word();
        case (a)
            16'h0160: return c[15:0];
            16'h0162: return c[31:16];
            16'h0164: return w[15:0];
            16'h0166: return w[31:16];
            default:  return 16'h0;
        endcase
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_wr(logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        case (a)
            16'h0160: m_stage = d;
            16'h0162: begin m_rdi = d[9]; m_wri = d[8]; m_obj = d[2:0]; m_addr = m_stage; end
            16'h0164: case (m_obj)
                3'd0: m_uc[m_addr % UC][15:0] = d;
                3'd1: m_sh[m_addr % SH][15:0] = d;
                3'd2: m_rf[m_addr % RF]       = d;
                3'd4: m_mt[m_addr % MT][15:0] = d;
                default: ;
            endcase
            16'h0166: begin
                case (m_obj)
                    3'd0: m_uc[m_addr % UC][31:16] = d;
                    3'd1: m_sh[m_addr % SH][31:16] = d;
                    3'd4: m_mt[m_addr % MT][31:16] = d;
                    default: ;
                endcase
                if (m_wri) m_addr = m_addr + 16'd1;
            end
            default: ;
        endcase
    endtask

    task automatic do_rd(logic [15:0] a, string req);
        logic [15:0] exp;
        exp = m_read(a);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check(req, bus_rdata, exp);
        if (a == 16'h0166 && m_rdi) m_addr = m_addr + 16'd1;
    endtask

    task automatic set_ctl(logic rdi, logic wri, logic [2:0] obj, logic [15:0] addr);
        do_wr(16'h0160, addr);
        do_wr(16'h0162, {6'b0, rdi, wri, 5'b0, obj});
    endtask

    task automatic fill(logic [2:0] obj, int depth);
        set_ctl(1'b0, 1'b1, obj, 16'h0);
        for (int i = 0; i < depth; i++) begin
            do_wr(16'h0164, 16'($urandom));
            do_wr(16'h0166, 16'($urandom));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] keep;
        void'($urandom(32'h00C0FFEE));
        m_rdi = 0; m_wri = 0; m_obj = 0; m_addr = 0; m_stage = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", bus_rdata, 16'h0);
        do_rd(16'h0160, "R1 ctl lo");
        do_rd(16'h0162, "R1 ctl hi");

        // R5: fill every object with increment-on-write runs
        fill(3'd0, UC); fill(3'd1, SH); fill(3'd2, RF); fill(3'd4, MT);
        do_rd(16'h0160, "R5 addr after fill");

        // R2: staging has no effect until the high half lands
        set_ctl(1'b0, 1'b0, 3'd1, 16'h0010);
        do_wr(16'h0160, 16'h1234);
        do_rd(16'h0160, "R2 staged lo not live");
        do_wr(16'h0162, 16'hFCF8);
        do_rd(16'h0160, "R2 committed addr");
        do_rd(16'h0162, "R2 reserved bits zero");
        set_ctl(1'b1, 1'b1, 3'd4, 16'h0003);
        do_rd(16'h0162, "R2 flag and object field");

        // R4: read increment and 16-bit wrap
        set_ctl(1'b1, 1'b0, 3'd1, 16'hFFFF);
        do_rd(16'h0166, "R4 read at FFFF");
        do_rd(16'h0160, "R4 wrap to 0000");
        // R6: low access and disabled increment keep the address
        do_rd(16'h0164, "R6 lo read");
        do_wr(16'h0164, 16'hAAAA);
        do_rd(16'h0160, "R6 addr after lo access");
        set_ctl(1'b0, 1'b0, 3'd0, 16'h0007);
        do_wr(16'h0166, 16'h5A5A);
        do_rd(16'h0166, "R6 hi no flags");
        do_rd(16'h0160, "R6 addr unchanged");

        // R8: modulo wrap within each object
        set_ctl(1'b0, 1'b0, 3'd1, 16'(SH + 5));
        do_wr(16'h0164, 16'hBEEF);
        set_ctl(1'b0, 1'b0, 3'd1, 16'd5);
        do_rd(16'h0164, "R8 shared wrap");
        set_ctl(1'b0, 1'b0, 3'd4, 16'(MT * 3 + 2));
        do_rd(16'h0166, "R8 match table wrap");

        // R7: write to the match table leaves the microcode store alone
        set_ctl(1'b0, 1'b0, 3'd4, 16'd9);
        do_wr(16'h0164, 16'h1111);
        set_ctl(1'b0, 1'b0, 3'd0, 16'd9);
        do_rd(16'h0164, "R7 object isolation");

        // R9: objects without storage
        set_ctl(1'b0, 1'b0, 3'd3, 16'd2);
        do_wr(16'h0164, 16'hFFFF);
        do_rd(16'h0164, "R9 obj3 reads zero");
        set_ctl(1'b0, 1'b0, 3'd7, 16'd2);
        do_rd(16'h0166, "R9 obj7 reads zero");
        set_ctl(1'b0, 1'b0, 3'd1, 16'd2);
        do_rd(16'h0164, "R9 shared untouched");

        // R10: register file high half
        set_ctl(1'b1, 1'b1, 3'd2, 16'd4);
        do_wr(16'h0166, 16'h7777);
        do_rd(16'h0160, "R10 hi write still steps");
        set_ctl(1'b0, 1'b0, 3'd2, 16'd4);
        do_rd(16'h0166, "R10 hi reads zero");
        do_rd(16'h0164, "R10 lo kept");

        // R11: stray offsets
        keep = m_read(16'h0160);
        do_wr(16'h0168, 16'hFFFF);
        do_wr(16'h0000, 16'hFFFF);
        do_rd(16'h0168, "R11 stray read");
        do_rd(16'h0160, "R11 control unchanged");
        check("R11 model steady", m_read(16'h0160), keep);

        // R3/R7: random mixed traffic
        for (int n = 0; n < 1500; n++) begin
            int op;
            op = int'($urandom % 10);
            if (op == 0) begin
                set_ctl(1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom % 2048));
            end else if (op < 3) begin
                do_wr((op == 1) ? 16'h0164 : 16'h0166, 16'($urandom));
            end else if (op < 8) begin
                do_rd(((op & 1) != 0) ? 16'h0164 : 16'h0166, "R3 random data read");
            end else if (op == 8) begin
                do_rd(16'h0160, "R4 random addr check");
            end else begin
                do_rd(16'h0160 + 16'(2 * ($urandom % 8)), "R11 random offset read");
            end
        end
        finish_run();
    end

endmodule